// File: doc/BRIEF.md
# Packet Stream Self-Test Engine

This block checks a packet FIFO path while the path stays in its normal place. It sits on both sides of the FIFO. On the write side a stream multiplexer chooses between user packets and packets made by an internal generator. On the read side a demultiplexer sends the FIFO output either to the user or to an internal checker. Software sets up a run over a small settings bus, which has a strobe, an 8-bit address and 32-bit data. Software then polls a 32-bit readback word for status and for two throughput counters.

During a run the generator writes packets into the FIFO. Software programs the packet count, the byte length, the seed value, a ramp or fixed payload, and two throttle gaps. The checker builds the same sequence again from the same settings. It compares every 64-bit beat it receives and checks that the end-of-packet flag is on the right beat. A run is either bounded by the packet count or continuous. A continuous run stops only when software clears go, and it always ends on a packet boundary. Software divides the beat counter by the cycle counter to get the throughput of the path.

Top module: `pkt_selftest`

Register offsets from the `BASE` parameter: +0 readback select (3 bits, reset value 1), +1 control, +2 packet setup, +3 throttle, +4 seed.

## Requirements
- R1: `rbData` depends on the select register. Select 1 returns status: bit 0 running, bit 1 done, bits 3:2 the error code, all other bits zero. Select 2 returns the beat counter and select 3 returns the cycle counter. Any other select value returns zero. After reset the select is 1 and the status reads 0.
- R2: A write to control with bit 0 (go) set starts a run. On the next cycle running is 1, done is 0, the error code is 00 and both counters are zero. Bit 1 of that write chooses continuous mode.
- R3: Packet setup holds the packet count in bits 17:0, the byte length in bits 30:18 and ramp mode in bit 31. A bounded run sends exactly the programmed number of packets. Each packet is ceil(length/8) beats long, and a length of 0 gives one beat. Only the last beat of a packet carries the last flag. Once every packet has come back through the checker, running falls and done rises. A count of 0 finishes one cycle after the start.
- R4: Beat k of a run, counted from 0 across all packets, carries `seed + k` in 64 bits with the seed zero-extended when ramp mode is set. Without ramp mode every beat carries `{seed, ~seed}`.
- R5: A data mismatch on any bit of a returned beat sets error bit 2 (code 01). A last flag that does not match the expected beat sets error bit 3 (code 10). Both bits stay set through done until the next start.
- R6: A write to control with go cleared stops the engine at once, with running and done both 0. The only exception is a continuous run that is in progress.
- R7: A continuous run ignores the packet count and keeps going. When software writes control with go cleared, the generator completes the packet it is sending and starts no new one. The engine waits until every sent packet has been checked, then raises done.
- R8: While running, user input is held off (`userInReady` 0), `userOutValid` is 0 and the FIFO output is always accepted. When not running, user traffic passes straight through in both directions.
- R9: Throttle bits 15:0 insert that number of idle cycles after each packet. Bits 23:16 insert that number of idle cycles after each beat that is not the last of its packet.
- R10: The beat counter counts the beats the checker accepts during the run. The cycle counter counts clock edges while running. For a bounded run with P packets of B beats through a zero-latency path, the cycle counter ends at P*B + P*(B-1)*beatGap + (P-1)*pktGap + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| setStb | input | 1 | Settings write strobe |
| setAddr | input | 8 | Settings address |
| setData | input | 32 | Settings write data |
| rbData | output | 32 | Readback word |
| userInData | input | 64 | User stream to FIFO, data |
| userInLast | input | 1 | User stream to FIFO, end of packet |
| userInValid | input | 1 | User stream to FIFO, valid |
| userInReady | output | 1 | User stream to FIFO, ready |
| userOutData | output | 64 | FIFO stream to user, data |
| userOutLast | output | 1 | FIFO stream to user, end of packet |
| userOutValid | output | 1 | FIFO stream to user, valid |
| userOutReady | input | 1 | FIFO stream to user, ready |
| fifoInData | output | 64 | Write side of FIFO, data |
| fifoInLast | output | 1 | Write side of FIFO, end of packet |
| fifoInValid | output | 1 | Write side of FIFO, valid |
| fifoInReady | input | 1 | Write side of FIFO, ready |
| fifoOutData | input | 64 | Read side of FIFO, data |
| fifoOutLast | input | 1 | Read side of FIFO, end of packet |
| fifoOutValid | input | 1 | Read side of FIFO, valid |
| fifoOutReady | output | 1 | Read side of FIFO, ready |

## Verification
The assertions check on every cycle that running and done are never both high, that a start clears the error code, that a stop while idle clears the status, and that user ports are fenced off during a run. They also check that a stalled generator beat stays stable and that done and the error bits hold. Other results only show up over whole runs, so the bench scenarios cover them. These are the payload sequence under every length, mode and throttle setting, the exact beat and cycle counts, error detection with a flipped data bit or a misplaced last flag, a continuous run that stops on a packet boundary, and plain user pass-through while idle.

// File: rtl/pkt_selftest_pkg.sv
`timescale 1ns/1ps
package pkt_selftest_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic start;      // one-cycle: clear datapath state, begin run
    logic active;     // engine owns the FIFO path
    logic genEnable;  // new packets may be started
    logic cont;       // continuous mode
  } stCtrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_DONE} stState_t;
endpackage

// File: rtl/pkt_selftest_ctrl.sv
`timescale 1ns/1ps
module pkt_selftest_ctrl
  import pkt_selftest_pkg::*;
#(
  parameter int BASE   = 0,
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 18,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setStb,
  input  logic [ADDR_W-1:0] setAddr,
  input  logic [WORD_W-1:0] setData,
  input  logic              sentAll,
  input  logic              drained,
  input  logic [1:0]        errCode,
  input  logic [WORD_W-1:0] xferCnt,
  input  logic [WORD_W-1:0] cycCnt,
  output stCtrl_t           ctrl,
  output logic [CNT_W-1:0]  pktCount,
  output logic [LEN_W-1:0]  pktLen,
  output logic              rampMode,
  output logic [WORD_W-1:0] seed,
  output logic [15:0]       pktGap,
  output logic [7:0]        beatGap,
  output logic              running,
  output logic              done,
  output logic [WORD_W-1:0] rbData
);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(BASE + 2);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(BASE + 3);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(BASE + 4);

  stState_t   state;
  logic       contReg;
  logic [2:0] rbSel;
  logic       wrCtrl;

  assign wrCtrl = setStb && (setAddr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      contReg  <= 1'b0;
      rbSel    <= 3'd1;
      pktCount <= '0;
      pktLen   <= '0;
      rampMode <= 1'b0;
      seed     <= '0;
      pktGap   <= '0;
      beatGap  <= '0;
    end else begin
      if (setStb && setAddr == A_SEL)  rbSel <= setData[2:0];
      if (setStb && setAddr == A_CFG) begin
        pktCount <= setData[CNT_W-1:0];
        pktLen   <= setData[CNT_W+LEN_W-1:CNT_W];
        rampMode <= setData[CNT_W+LEN_W];
      end
      if (setStb && setAddr == A_THR) begin
        pktGap  <= setData[15:0];
        beatGap <= setData[23:16];
      end
      if (setStb && setAddr == A_SEED) seed <= setData;
      if (wrCtrl) begin
        if (setData[0]) begin
          state   <= ST_RUN;
          contReg <= setData[1];
        end else if (state == ST_RUN && contReg) begin
          state <= ST_DRAIN;
        end else begin
          state <= ST_IDLE;
        end
      end else begin
        case (state)
          ST_RUN:   if (!contReg && sentAll && drained) state <= ST_DONE;
          ST_DRAIN: if (drained) state <= ST_DONE;
          default:  ;
        endcase
      end
    end
  end

  assign running        = (state == ST_RUN) || (state == ST_DRAIN);
  assign done           = (state == ST_DONE);
  assign ctrl.start     = wrCtrl && setData[0];
  assign ctrl.active    = running;
  assign ctrl.genEnable = (state == ST_RUN);
  assign ctrl.cont      = contReg;

  always_comb begin
    case (rbSel)
      3'd1:    rbData = {{(WORD_W-4){1'b0}}, errCode, done, running};
      3'd2:    rbData = xferCnt;
      3'd3:    rbData = cycCnt;
      default: rbData = '0;
    endcase
  end
endmodule

// File: rtl/pkt_selftest_dp.sv
`timescale 1ns/1ps
module pkt_selftest_dp
  import pkt_selftest_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 18,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  stCtrl_t           ctrl,
  input  logic [CNT_W-1:0]  pktCount,
  input  logic [LEN_W-1:0]  pktLen,
  input  logic              rampMode,
  input  logic [WORD_W-1:0] seed,
  input  logic [15:0]       pktGap,
  input  logic [7:0]        beatGap,
  input  logic [2*WORD_W-1:0] userInData,
  input  logic              userInLast,
  input  logic              userInValid,
  output logic              userInReady,
  output logic [2*WORD_W-1:0] userOutData,
  output logic              userOutLast,
  output logic              userOutValid,
  input  logic              userOutReady,
  output logic [2*WORD_W-1:0] fifoInData,
  output logic              fifoInLast,
  output logic              fifoInValid,
  input  logic              fifoInReady,
  input  logic [2*WORD_W-1:0] fifoOutData,
  input  logic              fifoOutLast,
  input  logic              fifoOutValid,
  output logic              fifoOutReady,
  output logic              sentAll,
  output logic              drained,
  output logic [1:0]        errCode,
  output logic [WORD_W-1:0] xferCnt,
  output logic [WORD_W-1:0] cycCnt
);
  localparam int DATA_W = 2 * WORD_W;
  localparam int BEAT_W = LEN_W - 2;   // holds ceil(maxLen/8)

  function automatic logic [DATA_W-1:0] pattern(input logic ramp,
      input logic [WORD_W-1:0] s, input logic [WORD_W-1:0] idx);
    return ramp ? (DATA_W'(s) + DATA_W'(idx)) : {s, ~s};
  endfunction

  logic [BEAT_W-1:0] beatsPerPkt, lastBeat;
  logic [LEN_W:0]    lenRound;
  assign lenRound    = {1'b0, pktLen} + (LEN_W+1)'(7);
  assign beatsPerPkt = (pktLen == '0) ? BEAT_W'(1) : lenRound[LEN_W:3];
  assign lastBeat    = beatsPerPkt - BEAT_W'(1);

  // Generator state
  logic [BEAT_W-1:0] genBeat;
  logic [WORD_W-1:0] genIdx;
  logic [CNT_W-1:0]  sentCnt;
  logic [15:0]       idleCnt;
  logic              genValid, genFire, genLast;
  // Checker state
  logic [BEAT_W-1:0] chkBeat;
  logic [WORD_W-1:0] chkIdx;
  logic [CNT_W-1:0]  chkCnt;
  logic              chkFire;

  assign sentAll  = (sentCnt == pktCount);
  assign drained  = (genBeat == '0) && (chkCnt == sentCnt);
  assign genLast  = (genBeat == lastBeat);
  assign genValid = ctrl.active && (idleCnt == '0) &&
                    ((genBeat != '0) || (ctrl.genEnable && (ctrl.cont || !sentAll)));
  assign genFire  = genValid && fifoInReady;
  assign chkFire  = ctrl.active && fifoOutValid;

  always_ff @(posedge clk) begin
    if (rst || ctrl.start) begin
      genBeat <= '0; genIdx <= '0; sentCnt <= '0; idleCnt <= '0;
      chkBeat <= '0; chkIdx <= '0; chkCnt <= '0;
      errCode <= '0; xferCnt <= '0; cycCnt <= '0;
    end else begin
      if (genFire) begin
        genIdx <= genIdx + 1'b1;
        if (genLast) begin
          genBeat <= '0;
          sentCnt <= sentCnt + 1'b1;
          idleCnt <= pktGap;
        end else begin
          genBeat <= genBeat + 1'b1;
          idleCnt <= 16'(beatGap);
        end
      end else if (ctrl.active && idleCnt != '0) begin
        idleCnt <= idleCnt - 1'b1;
      end
      if (chkFire) begin
        if (fifoOutData != pattern(rampMode, seed, chkIdx)) errCode[0] <= 1'b1;
        if (fifoOutLast != (chkBeat == lastBeat))           errCode[1] <= 1'b1;
        chkIdx  <= chkIdx + 1'b1;
        xferCnt <= xferCnt + 1'b1;
        if (fifoOutLast) begin
          chkBeat <= '0;
          chkCnt  <= chkCnt + 1'b1;
        end else begin
          chkBeat <= chkBeat + 1'b1;
        end
      end
      if (ctrl.active) cycCnt <= cycCnt + 1'b1;
    end
  end

  // Input multiplexer and output demultiplexer
  assign fifoInValid  = ctrl.active ? genValid : userInValid;
  assign fifoInData   = ctrl.active ? pattern(rampMode, seed, genIdx) : userInData;
  assign fifoInLast   = ctrl.active ? genLast : userInLast;
  assign userInReady  = !ctrl.active && fifoInReady;
  assign userOutValid = !ctrl.active && fifoOutValid;
  assign userOutData  = fifoOutData;
  assign userOutLast  = fifoOutLast;
  assign fifoOutReady = ctrl.active || userOutReady;
endmodule

// File: rtl/pkt_selftest.sv
`timescale 1ns/1ps
module pkt_selftest
  import pkt_selftest_pkg::*;
#(
  parameter int BASE   = 0,
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 18,
  parameter int LEN_W  = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                setStb,
  input  logic [ADDR_W-1:0]   setAddr,
  input  logic [WORD_W-1:0]   setData,
  output logic [WORD_W-1:0]   rbData,
  input  logic [2*WORD_W-1:0] userInData,
  input  logic                userInLast,
  input  logic                userInValid,
  output logic                userInReady,
  output logic [2*WORD_W-1:0] userOutData,
  output logic                userOutLast,
  output logic                userOutValid,
  input  logic                userOutReady,
  output logic [2*WORD_W-1:0] fifoInData,
  output logic                fifoInLast,
  output logic                fifoInValid,
  input  logic                fifoInReady,
  input  logic [2*WORD_W-1:0] fifoOutData,
  input  logic                fifoOutLast,
  input  logic                fifoOutValid,
  output logic                fifoOutReady
);
  stCtrl_t           ctrl;
  logic [CNT_W-1:0]  pktCount;
  logic [LEN_W-1:0]  pktLen;
  logic              rampMode, sentAll, drained, running, done;
  logic [WORD_W-1:0] seed, xferCnt, cycCnt;
  logic [15:0]       pktGap;
  logic [7:0]        beatGap;
  logic [1:0]        errCode;

  pkt_selftest_ctrl #(.BASE(BASE), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
                      .CNT_W(CNT_W), .LEN_W(LEN_W)) i_ctrl (
    .clk, .rst, .setStb, .setAddr, .setData, .sentAll, .drained, .errCode,
    .xferCnt, .cycCnt, .ctrl, .pktCount, .pktLen, .rampMode, .seed, .pktGap,
    .beatGap, .running, .done, .rbData
  );

  pkt_selftest_dp #(.WORD_W(WORD_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) i_dp (
    .clk, .rst, .ctrl, .pktCount, .pktLen, .rampMode, .seed, .pktGap, .beatGap,
    .userInData, .userInLast, .userInValid, .userInReady,
    .userOutData, .userOutLast, .userOutValid, .userOutReady,
    .fifoInData, .fifoInLast, .fifoInValid, .fifoInReady,
    .fifoOutData, .fifoOutLast, .fifoOutValid, .fifoOutReady,
    .sentAll, .drained, .errCode, .xferCnt, .cycCnt
  );
endmodule

// File: rtl/pkt_selftest_sva.sv
`timescale 1ns/1ps
module pkt_selftest_sva #(
  parameter int BASE   = 0,
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                setStb,
  input logic [ADDR_W-1:0]   setAddr,
  input logic [WORD_W-1:0]   setData,
  input logic                running,
  input logic                done,
  input logic [1:0]          errCode,
  input logic                userInReady,
  input logic                userOutValid,
  input logic                fifoOutValid,
  input logic                fifoOutReady,
  input logic [2*WORD_W-1:0] fifoInData,
  input logic                fifoInLast,
  input logic                fifoInValid,
  input logic                fifoInReady
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + 1);

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(running && done)); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (setStb && setAddr == A_CTRL && setData[0]) |=> (running && !done && errCode == 2'b00)); // R2
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (setStb && setAddr == A_CTRL && !setData[0] && !running) |=> (!running && !done)); // R6
  AST_USER_FENCED: assert property (@(posedge clk) disable iff (rst)
    running |-> (!userInReady && !userOutValid && fifoOutReady)); // R8
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!running && fifoOutValid) |-> userOutValid); // R8
  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (running && fifoInValid && !fifoInReady && !setStb) |=>
      (fifoInValid && $stable(fifoInData) && $stable(fifoInLast))); // R3
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !setStb) |=> (done && $stable(errCode))); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (running && errCode[0] && !setStb) |=> errCode[0]); // R5
endmodule

bind pkt_selftest pkt_selftest_sva #(.BASE(BASE), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_sva (
  .clk, .rst, .setStb, .setAddr, .setData, .running, .done, .errCode,
  .userInReady, .userOutValid, .fifoOutValid, .fifoOutReady,
  .fifoInData, .fifoInLast, .fifoInValid, .fifoInReady
);

// File: tb/test_pkt_selftest.sv
`timescale 1ns/1ps
module test_pkt_selftest;
  logic        clk = 1'b0, rst = 1'b1;
  logic        setStb = 1'b0;
  logic [7:0]  setAddr = '0;
  logic [31:0] setData = '0, rbData;
  logic [63:0] userInData = '0, userOutData, fifoInData, fifoOutData;
  logic        userInLast = 1'b0, userInValid = 1'b0, userInReady;
  logic        userOutLast, userOutValid, userOutReady = 1'b0;
  logic        fifoInLast, fifoInValid, fifoInReady;
  logic        fifoOutLast, fifoOutValid, fifoOutReady;
  logic [63:0] flipMask = '0;
  logic        lastFlip = 1'b0;

  int nVec = 0, nBad = 0;
  // monitor model
  logic        monOn = 1'b0, mRamp = 1'b0;
  logic [31:0] mSeed = '0, mIdx = '0;
  int          mBeat = 0, mB = 1;

  always #5 clk = ~clk;

  // zero-latency loopback standing in for the FIFO, with fault injection
  assign fifoOutValid = fifoInValid;
  assign fifoOutData  = fifoInData ^ flipMask;
  assign fifoOutLast  = fifoInLast ^ lastFlip;
  assign fifoInReady  = fifoOutReady;

  pkt_selftest i_pkt_selftest (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (monOn && fifoInValid && fifoInReady) begin
      chk("R4 payload", fifoInData, mRamp ? (64'(mSeed) + 64'(mIdx)) : {mSeed, ~mSeed});
      chk("R3 last flag", 64'(fifoInLast), 64'(mBeat == mB - 1));
      mIdx++;
      mBeat = (mBeat == mB - 1) ? 0 : mBeat + 1;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    setStb = 1'b1; setAddr = a; setData = d;
    @(negedge clk);
    setStb = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!rbData[1] && n < 60000) begin @(negedge clk); n++; end
    if (n >= 60000) chk({tag, " watchdog done"}, 0, 1);
  endtask

  function automatic int beatsOf(input int len);
    return (len == 0) ? 1 : (len + 7) / 8;
  endfunction

  task automatic arm(input int cnt, input int len, input bit ramp, input logic [31:0] sd,
                     input int pg, input int bg, input bit cont);
    wr(8'd2, {ramp, 13'(len), 18'(cnt)});
    wr(8'd3, {8'd0, 8'(bg), 16'(pg)});
    wr(8'd4, sd);
    mRamp = ramp; mSeed = sd; mIdx = '0; mBeat = 0; mB = beatsOf(len);
    wr(8'd1, {30'd0, cont, 1'b1});
  endtask

  task automatic boundedRun(input int cnt, input int len, input bit ramp,
                            input logic [31:0] sd, input int pg, input int bg);
    int b = beatsOf(len);
    int expCyc = cnt * b + cnt * (b - 1) * bg + ((cnt > 0) ? (cnt - 1) * pg : 0) + 1;
    monOn = 1'b1;
    arm(cnt, len, ramp, sd, pg, bg, 1'b0);
    if (cnt > 0) chk("R2 running after start", 64'(rbData[3:0]), 64'h1);
    waitDone("R3");
    chk("R3 done, no error", 64'(rbData[3:0]), 64'h2);
    monOn = 1'b0;
    wr(8'd0, 32'd2);
    chk("R10 beat count", 64'(rbData), 64'(cnt * b));
    wr(8'd0, 32'd3);
    chk("R10 R9 cycle count", 64'(rbData), 64'(expCyc));
    wr(8'd0, 32'd1);
  endtask

  initial begin
    #1_800_000;
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    int lens[8] = '{1, 7, 8, 9, 16, 24, 40, 65};
    int xfer;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", 64'(rbData), 64'h0);
    wr(8'd0, 32'd5);
    chk("R1 unused select reads zero", 64'(rbData), 64'h0);
    wr(8'd0, 32'd1);

    // R8 idle pass-through
    userOutReady = 1'b1; userInValid = 1'b1; userInData = 64'hDEAD_BEEF_0123_4567; userInLast = 1'b1;
    @(negedge clk);
    chk("R8 idle userOutValid", 64'(userOutValid), 64'h1);
    chk("R8 idle data through", userOutData, 64'hDEAD_BEEF_0123_4567);
    chk("R8 idle userInReady", 64'(userInReady), 64'h1);
    userInValid = 1'b0;

    // sweep of lengths, modes, counts and throttles
    for (int li = 0; li < 8; li++)
      for (int r = 0; r < 2; r++)
        for (int c = 1; c <= 3; c += 2)
          boundedRun(c, lens[li], r[0], 32'h1234_5670 + 32'(li), (li + c) % 3, (li + r) % 2);
    boundedRun(0, 16, 1'b0, 32'h0, 0, 0);     // R3 zero count
    boundedRun(2, 0, 1'b1, 32'hFFFF_FFFF, 1, 0); // R3 zero length, R4 seed carry

    // R5 data mismatch
    flipMask = 64'h8000_0000_0000_0000;
    arm(2, 16, 1'b0, 32'h0ABC_DEF0, 0, 0, 1'b0);
    waitDone("R5");
    flipMask = '0;
    chk("R5 mismatch code 01", 64'(rbData[3:0]), 64'h6);
    repeat (4) @(negedge clk);
    chk("R5 code sticky", 64'(rbData[3:0]), 64'h6);
    // R5 framing error
    lastFlip = 1'b1;
    arm(1, 24, 1'b1, 32'h5, 0, 0, 1'b0);
    repeat (10) @(negedge clk);
    lastFlip = 1'b0;
    chk("R5 framing code 10", 64'(rbData[3:2]), 64'h2);
    wr(8'd1, 32'd0);
    arm(1, 8, 1'b0, 32'h7, 0, 0, 1'b0);
    waitDone("R5");
    chk("R5 cleared by start", 64'(rbData[3:0]), 64'h2);

    // R6 stop a bounded run early
    monOn = 1'b1;
    arm(1000, 64, 1'b1, 32'h99, 0, 0, 1'b0);
    repeat (5) @(negedge clk);
    wr(8'd1, 32'd0);
    chk("R6 stop clears status", 64'(rbData[1:0]), 64'h0);
    monOn = 1'b0;

    // R7 continuous run, R8 fencing
    monOn = 1'b1;
    arm(2, 24, 1'b1, 32'h4000_0000, 1, 0, 1'b1);
    repeat (60) @(negedge clk);
    chk("R7 still running past count", 64'(rbData[1:0]), 64'h1);
    userInValid = 1'b1;
    @(negedge clk);
    chk("R8 user input held", 64'(userInReady), 64'h0);
    chk("R8 user output blank", 64'(userOutValid), 64'h0);
    userInValid = 1'b0;
    wr(8'd1, 32'd0);
    waitDone("R7");
    chk("R7 done after drain", 64'(rbData[3:0]), 64'h2);
    monOn = 1'b0;
    wr(8'd0, 32'd2);
    xfer = int'(rbData);
    chk("R7 whole packets only", 64'(xfer % 3), 64'h0);
    chk("R7 beyond programmed count", 64'(xfer > 6), 64'h1);
    wr(8'd0, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule